// File: doc/BRIEF.md
# DRAM Refresh and Low-Power Manager

This block sits on the controller side of a four-bank DDR SDRAM and owns every refresh and every CKE transition. A free-running interval counter adds one owed refresh per interval to a small debt counter. While any refresh is owed the block raises a request to the command arbiter, and it flags the request as urgent once the postponement limit is reached. When the arbiter grants, the block closes all banks with a precharge-all if any is open and waits the row precharge time. It then issues an auto-refresh and keeps a busy flag high for the refresh cycle time. During that window it drives only NOP.

The same granted slot can also be used to put the device into self refresh or precharge-style power down by lowering CKE. Self refresh is an auto-refresh command sent with CKE low. It clears the debt and pauses the interval counter. On release the block raises CKE and stays busy for the long self-refresh exit time. Power down drops CKE with NOP on the bus and, on release, stays busy for the short power-down exit time. Neither low-power state is entered while the arbiter reports a read or write in flight.

The state machine has ten named states:
- IDLE: nothing pending, or waiting for a grant.
- PALL: the precharge-all cycle.
- WAIT_RP: the row precharge wait.
- REF: the auto-refresh cycle.
- WAIT_RFC: the refresh hold-off.
- SR_ENTER: auto-refresh with CKE low.
- SR_HOLD: in self refresh.
- SR_EXIT: the self-refresh exit wait.
- PD_HOLD: in power down.
- PD_EXIT: the power-down exit wait.

The transitions are as follows:
- IDLE leaves only with a grant. Its priority is self refresh, then a pending refresh, then power down.
- IDLE goes to PALL or straight to REF or SR_ENTER, depending on whether a bank is open.
- PALL goes to WAIT_RP, and WAIT_RP goes to REF or SR_ENTER once the precharge time is up.
- REF goes to WAIT_RFC, and WAIT_RFC goes to IDLE.
- SR_ENTER goes to SR_HOLD. SR_HOLD goes to SR_EXIT when the self-refresh request drops, and SR_EXIT goes to IDLE.
- PD_HOLD goes to PD_EXIT when the power-down request drops, and PD_EXIT goes to IDLE.

Top module: `dram_refresh_pm`

## Requirements
- R1: Out of reset the first refresh becomes owed (ref_req high) exactly REF_INTERVAL clock edges after reset release, and one more is owed every REF_INTERVAL edges after that.
- R2: Owed refreshes accumulate up to MAX_DEBT. ref_urgent is high exactly when MAX_DEBT are owed, and further intervals add nothing. A later grant therefore issues exactly MAX_DEBT refreshes before ref_req drops.
- R3: With a grant, a refresh owed and no bank open (no sr_req), the next cycle carries auto-refresh: cs_n=0, ras_n=0, cas_n=0, we_n=1, cke=1. No precharge is sent. Any command other than NOP (NOP is cs_n=0, ras_n=cas_n=we_n=1) appears only while busy is high.
- R4: With a bank open, precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1) is sent first. The refresh follows exactly T_RP cycles after it.
- R5: From the auto-refresh cycle, busy stays high for exactly T_RFC cycles. Only NOP is driven after the refresh within that window.
- R6: If an interval expires in the very cycle an auto-refresh is issued, the owed count is unchanged: one added, one paid.
- R7: Self refresh is entered by an auto-refresh with cke=0. It clears all owed refreshes. cke stays low and no refresh becomes owed while sr_req stays high. After sr_req drops, busy stays high for exactly T_XSR cycles counted from the cycle cke returns high.
- R8: Power down drives cke=0 with NOP while pd_req stays high. After release, busy stays high for exactly T_XP cycles counted from the cycle cke returns high.
- R9: No low-power entry and no refresh starts without ref_grant. Power down and self refresh are not entered while xfer_active is high.
- R10: During and right after reset: cke=1, NOP on the bus, busy=0, ref_req=0, ref_urgent=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_grant | input | 1 | Arbiter hands the command bus to this block |
| bank_open | input | 1 | At least one bank is active |
| xfer_active | input | 1 | A read or write burst is in flight |
| sr_req | input | 1 | Request to enter and hold self refresh (level) |
| pd_req | input | 1 | Request to enter and hold power down (level) |
| ref_req | output | 1 | At least one refresh is owed |
| ref_urgent | output | 1 | Postponement limit reached |
| busy | output | 1 | Arbiter must stay off the bus |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10, high selects all banks for precharge |

## Verification
The interval timer and the refresh issue path can act in the same clock edge. One adds an owed refresh while the other pays one off. The bench provokes this by raising the grant so that the auto-refresh cycle ends on the very edge where the interval expires, with exactly one refresh owed beforehand. It judges the result at the ports: after the hold-off, ref_req must still be high, whereas a design that let either update win would show it low or need two more refreshes. Saturation at the postponement limit is judged the same way, by counting the refresh commands that a single long grant produces.

// File: rtl/dram_rpm_pkg.sv
package dram_rpm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PALL,
        ST_WAIT_RP,
        ST_REF,
        ST_WAIT_RFC,
        ST_SR_ENTER,
        ST_SR_HOLD,
        ST_SR_EXIT,
        ST_PD_HOLD,
        ST_PD_EXIT
    } rpm_state_e;

    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } pin_cmd_t;

    localparam pin_cmd_t PIN_NOP  = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    localparam pin_cmd_t PIN_PALL = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
    localparam pin_cmd_t PIN_AREF = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
    localparam pin_cmd_t PIN_SREF = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};
    localparam pin_cmd_t PIN_LOWP = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};

endpackage

// File: rtl/rpm_phase_timer.sv
module rpm_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/rpm_debt_tracker.sv
module rpm_debt_tracker #(
    parameter int INTERVAL = 2727,
    parameter int MAX_DEBT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic clear,
    input  logic take,
    output logic owed,
    output logic full
);
    localparam int IW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam int DW = $clog2(MAX_DEBT + 1);
    localparam logic [IW-1:0] RELOAD = IW'(INTERVAL - 1);
    localparam logic [DW-1:0] CAP    = DW'(MAX_DEBT);

    logic [IW-1:0] icnt;
    logic [DW-1:0] debt;
    logic          tick;

    assign tick = !hold && (icnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            icnt <= RELOAD;
        end else if (hold || icnt == '0) begin
            icnt <= RELOAD;
        end else begin
            icnt <= icnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            debt <= '0;
        end else begin
            unique case ({tick, take})
                2'b10:   if (debt != CAP) debt <= debt + 1'b1;
                2'b01:   if (debt != '0) debt <= debt - 1'b1;
                default: debt <= debt;
            endcase
        end
    end

    assign owed = (debt != '0);
    assign full = (debt == CAP);
endmodule

// File: rtl/dram_refresh_pm.sv
module dram_refresh_pm
    import dram_rpm_pkg::*;
#(
    parameter int CLK_PS       = 2860,
    parameter int REF_INTERVAL = 7_800_000 / CLK_PS,
    parameter int MAX_DEBT     = 8,
    parameter int T_RP         = 5,
    parameter int T_RFC        = 17,
    parameter int T_XSR        = 200,
    parameter int T_XP         = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_grant,
    input  logic bank_open,
    input  logic xfer_active,
    input  logic sr_req,
    input  logic pd_req,
    output logic ref_req,
    output logic ref_urgent,
    output logic busy,
    output logic cke,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic a10
);
    localparam int M1   = (T_RP > T_RFC) ? T_RP : T_RFC;
    localparam int M2   = (T_XSR > T_XP) ? T_XSR : T_XP;
    localparam int TMAX = (M1 > M2) ? M1 : M2;
    localparam int TW   = $clog2(TMAX + 1);

    rpm_state_e    state, nxt;
    logic          goal_sr;
    logic          sr_go, ref_go, pd_go;
    logic          tm_load, tm_done;
    logic [TW-1:0] tm_val;
    logic          owed, full;
    pin_cmd_t      pins;

    assign sr_go  = ref_grant && sr_req && !xfer_active;
    assign ref_go = ref_grant && owed;
    assign pd_go  = ref_grant && pd_req && !xfer_active;

    rpm_debt_tracker #(
        .INTERVAL (REF_INTERVAL),
        .MAX_DEBT (MAX_DEBT)
    ) u_debt (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (state == ST_SR_ENTER || state == ST_SR_HOLD),
        .clear (state == ST_SR_ENTER),
        .take  (state == ST_REF),
        .owed  (owed),
        .full  (full)
    );

    rpm_phase_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .done     (tm_done)
    );

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (sr_go)       nxt = bank_open ? ST_PALL : ST_SR_ENTER;
                else if (ref_go) nxt = bank_open ? ST_PALL : ST_REF;
                else if (pd_go)  nxt = ST_PD_HOLD;
            end
            ST_PALL:     nxt = ST_WAIT_RP;
            ST_WAIT_RP:  if (tm_done) nxt = goal_sr ? ST_SR_ENTER : ST_REF;
            ST_REF:      nxt = ST_WAIT_RFC;
            ST_WAIT_RFC: if (tm_done) nxt = ST_IDLE;
            ST_SR_ENTER: nxt = ST_SR_HOLD;
            ST_SR_HOLD:  if (!sr_req) nxt = ST_SR_EXIT;
            ST_SR_EXIT:  if (tm_done) nxt = ST_IDLE;
            ST_PD_HOLD:  if (!pd_req) nxt = ST_PD_EXIT;
            ST_PD_EXIT:  if (tm_done) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // timer load on entry into a waiting state
    always_comb begin
        tm_load = 1'b0;
        tm_val  = '0;
        if (nxt != state) begin
            unique case (nxt)
                ST_WAIT_RP:  begin tm_load = 1'b1; tm_val = TW'(T_RP - 2);  end
                ST_WAIT_RFC: begin tm_load = 1'b1; tm_val = TW'(T_RFC - 2); end
                ST_SR_EXIT:  begin tm_load = 1'b1; tm_val = TW'(T_XSR - 1); end
                ST_PD_EXIT:  begin tm_load = 1'b1; tm_val = TW'(T_XP - 1);  end
                default:     begin tm_load = 1'b0; tm_val = '0;             end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            goal_sr <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE) goal_sr <= sr_go;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_PALL:     pins = PIN_PALL;
            ST_REF:      pins = PIN_AREF;
            ST_SR_ENTER: pins = PIN_SREF;
            ST_SR_HOLD,
            ST_PD_HOLD:  pins = PIN_LOWP;
            default:     pins = PIN_NOP;
        endcase
    end

    assign cke        = pins.cke;
    assign cs_n       = pins.cs_n;
    assign ras_n      = pins.ras_n;
    assign cas_n      = pins.cas_n;
    assign we_n       = pins.we_n;
    assign a10        = pins.a10;
    assign busy       = (state != ST_IDLE);
    assign ref_req    = owed;
    assign ref_urgent = full;
endmodule

// File: rtl/rpm_checker.sv
module rpm_checker (
    input logic clk,
    input logic rst_n,
    input logic xfer_active,
    input logic ref_req,
    input logic ref_urgent,
    input logic busy,
    input logic cke,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic a10
);
    logic is_nop_bus, is_pall, is_aref;

    assign is_nop_bus = !cs_n && ras_n && cas_n && we_n;
    assign is_pall    = !cs_n && !ras_n && cas_n && !we_n;
    assign is_aref    = !cs_n && !ras_n && !cas_n && we_n;

    // R2: urgency only with something owed
    a_r2_urgent_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent |-> ref_req);

    // R3: commands only while the arbiter is held off
    a_r3_cmd_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !is_nop_bus) |-> busy);

    // R4: precharge from this block always closes every bank
    a_r4_pall_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        is_pall |-> a10);

    // R5: the cycle after an auto-refresh is a busy NOP
    a_r5_nop_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (is_aref && cke) |=> (busy && is_nop_bus && cke));

    // R8: nothing but NOP while clocking stays disabled
    a_r8_nop_in_lowpower: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !$past(cke)) |-> is_nop_bus);

    // R9: power-down entry never during a data burst
    a_r9_no_pd_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cke) && ras_n) |-> !$past(xfer_active));
endmodule

bind dram_refresh_pm rpm_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_active (xfer_active),
    .ref_req     (ref_req),
    .ref_urgent  (ref_urgent),
    .busy        (busy),
    .cke         (cke),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .a10         (a10)
);

// File: tb/sim_dram_refresh_pm.sv
module sim_dram_refresh_pm;
    localparam int CLK_PERIOD = 10;
    localparam int INTV = 150;
    localparam int DEBT = 8;
    localparam int TRP  = 5;
    localparam int TRFC = 17;
    localparam int TXSR = 200;
    localparam int TXP  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_grant = 1'b0, bank_open = 1'b0, xfer_active = 1'b0;
    logic sr_req = 1'b0, pd_req = 1'b0;
    logic ref_req, ref_urgent, busy, cke, cs_n, ras_n, cas_n, we_n, a10;

    int nchk = 0, nerr = 0;
    int pcount = 0;
    int ref_cnt = 0, pall_cnt = 0, pall_at = 0, ref_at = 0, rise_at = 0;
    int exit_len = 0, nop_bad = 0;
    bit pall_pend = 0, rfc_pend = 0, exit_pend = 0, exit_done = 0, prev_cke = 1;
    bit reported = 0;

    dram_refresh_pm #(
        .REF_INTERVAL (INTV), .MAX_DEBT (DEBT), .T_RP (TRP),
        .T_RFC (TRFC), .T_XSR (TXSR), .T_XP (TXP)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .ref_grant (ref_grant), .bank_open (bank_open),
        .xfer_active (xfer_active), .sr_req (sr_req), .pd_req (pd_req),
        .ref_req (ref_req), .ref_urgent (ref_urgent), .busy (busy), .cke (cke),
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .a10 (a10)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) if (rst_n) pcount <= pcount + 1;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        end
        $finish;
    endtask

    function automatic bit bus_nop();
        return !cs_n && ras_n && cas_n && we_n;
    endfunction

    function automatic bit bus_ref();
        return !cs_n && !ras_n && !cas_n && we_n;
    endfunction

    // port monitor: timing of precharge, refresh and exits
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n && !ras_n && cas_n && !we_n) begin
                pall_cnt++; pall_at = pcount; pall_pend = 1;
            end
            if (rfc_pend && !busy) begin
                chk("R5 refresh hold-off length", pcount - ref_at, TRFC);
                rfc_pend = 0;
            end
            if (rfc_pend && pcount > ref_at && !bus_nop()) nop_bad++;
            if (bus_ref()) begin
                if (pall_pend) chk("R4 precharge-to-refresh spacing", pcount - pall_at, TRP);
                pall_pend = 0;
                if (cke) begin
                    ref_cnt++; ref_at = pcount; rfc_pend = 1;
                end
            end
            if (cke && !prev_cke) begin
                rise_at = pcount; exit_pend = 1;
            end
            if (exit_pend && !busy) begin
                exit_len = pcount - rise_at; exit_pend = 0; exit_done = 1;
            end
            prev_cke = cke;
        end
    end

    task automatic step(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic refresh_once(input bit open);
        int p0;
        p0 = pall_cnt;
        while (!ref_req) step(1);
        bank_open = open;
        ref_grant = 1'b1;
        step(1);
        if (open) begin
            chk("R4 precharge-all first", int'(!cs_n && !ras_n && cas_n && !we_n && a10), 1);
        end else begin
            chk("R3 refresh one cycle after grant", int'(bus_ref() && cke && busy), 1);
        end
        ref_grant = 1'b0;
        bank_open = 1'b0;
        while (busy) step(1);
        chk(open ? "R4 one precharge issued" : "R3 no precharge when closed",
            pall_cnt - p0, open ? 1 : 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=%0d expected=0", pcount);
        report();
    end

    initial begin
        int r0, k;
        bit bad;
        step(3);
        chk("R10 cke in reset", cke, 1);
        chk("R10 NOP in reset", int'(bus_nop()), 1);
        chk("R10 busy in reset", busy, 0);
        rst_n = 1'b1;
        step(1);
        chk("R10 ref_req after reset", ref_req, 0);
        chk("R10 ref_urgent after reset", ref_urgent, 0);

        // R1 first interval
        while (!ref_req) step(1);
        chk("R1 first refresh owed at", pcount, INTV);
        chk("R2 not urgent with one owed", ref_urgent, 0);

        // R2 accumulation and saturation
        while (pcount < (DEBT - 1) * INTV + INTV - 1) step(1);
        chk("R2 urgent one edge early", ref_urgent, 0);
        step(1);
        chk("R2 urgent at limit", ref_urgent, 1);
        while (pcount < (DEBT + 1) * INTV) step(1);
        r0 = ref_cnt;
        ref_grant = 1'b1;
        while (ref_req || busy) step(1);
        ref_grant = 1'b0;
        chk("R2 refreshes after saturation", ref_cnt - r0, DEBT);

        // R3, R4, R5 single refreshes
        refresh_once(1'b0);
        refresh_once(1'b1);
        refresh_once(1'b0);

        // R6 tick coincides with refresh issue
        while (ref_req) refresh_once(1'b0);
        k = pcount / INTV + 2;
        while (pcount < k * INTV - 2) step(1);
        chk("R6 one refresh owed before", ref_req, 1);
        ref_grant = 1'b1;
        step(1);
        chk("R6 refresh issued on expiry cycle", int'(bus_ref()), 1);
        ref_grant = 1'b0;
        while (busy) step(1);
        chk("R6 owed count kept", ref_req, 1);
        refresh_once(1'b0);

        // R9 no action without grant; R8 power down
        while (ref_req) refresh_once(1'b0);
        pd_req = 1'b1;
        sr_req = 1'b0;
        bad = 0;
        for (int i = 0; i < 6; i++) begin
            step(1);
            if (!cke || busy) bad = 1;
        end
        chk("R9 no entry without grant", bad, 0);
        xfer_active = 1'b1;
        ref_grant = 1'b1;
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (!cke || busy) bad = 1;
        end
        chk("R9 no power down during burst", bad, 0);
        xfer_active = 1'b0;
        step(1);
        chk("R8 cke low after burst ends", cke, 0);
        step(10);
        chk("R8 cke held low", cke, 0);
        chk("R8 NOP while powered down", int'(bus_nop()), 1);
        exit_done = 0;
        pd_req = 1'b0;
        ref_grant = 1'b0;
        while (!exit_done) step(1);
        chk("R8 power-down exit length", exit_len, TXP);

        // R7 self refresh with a bank open and a refresh owed
        while (!ref_req) step(1);
        bank_open = 1'b1;
        sr_req = 1'b1;
        ref_grant = 1'b1;
        while (cke) step(1);
        chk("R7 entry is refresh with cke low", int'(bus_ref()), 1);
        ref_grant = 1'b0;
        bank_open = 1'b0;
        step(1);
        chk("R7 owed refreshes cleared", ref_req, 0);
        bad = 0;
        for (int i = 0; i < 3 * INTV; i++) begin
            step(1);
            if (cke || ref_req) bad = 1;
        end
        chk("R7 held in self refresh, interval paused", bad, 0);
        exit_done = 0;
        sr_req = 1'b0;
        while (!exit_done) step(1);
        chk("R7 self-refresh exit length", exit_len, TXSR);

        chk("R5 only NOP inside hold-off", nop_bad, 0);
        report();
    end
endmodule